// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

The controller gathers interrupt requests from five classes of source: a non-maskable input, a debug-break request, a serial-debug request, a set of external IRQ lines and a set of peripheral request lines. Each source carries a priority level from 0 to 16. The non-maskable source is fixed at 16, the two debug sources are fixed at 15, and every IRQ and peripheral source takes its level from a 4-bit priority register that software writes through a simple write port. Level 0 keeps a source masked at all times.

Every cycle the block picks the highest-level pending source whose level beats the current 4-bit mask from the CPU status register. It presents the winner as `accept_o` with a source number and the mask value that exception entry must write back. The non-maskable source always wins, because 16 exceeds any 4-bit mask, but it writes back 15. The CPU answers with `ack_i`, which clears the latched request of the source shown in that cycle. Edge-triggered sources keep their request latched until it is acknowledged. Level-triggered sources follow their input.

Top module: `intc_accept`

## Requirements
- R1: A source whose priority level is 0 is never accepted, whatever the mask value.
- R2: A pending non-maskable request is accepted whatever `mask_i` holds. It reports source number 0 and `new_mask_o` = 15.
- R3: The non-maskable input is synchronized and edge-detected: `nmi_rise_i`=1 selects rising edges and 0 selects falling edges. Toggling `nmi_rise_i` while the input is steady creates no request. A latched request stays pending until it is acknowledged.
- R4: The debug-break request is level-sensitive with fixed level 15. It is accepted only while `mask_i` < 15, and on acceptance `new_mask_o` = 15.
- R5: The serial-debug request is detected on a rising edge and latched until acknowledged. It has fixed level 15 and gives `new_mask_o` = 15.
- R6: An IRQ or peripheral source is accepted only when its programmed level is strictly greater than `mask_i`.
- R7: The highest level wins, and equal levels are broken by source number, lowest first. The numbering is: 0 non-maskable, 1 debug-break, 2 serial-debug, 3..3+N_IRQ-1 IRQ lines, then peripherals in index order.
- R8: For IRQ and peripheral sources, `new_mask_o` equals the accepted source's programmed level.
- R9: `ack_i` while `accept_o` is high clears the latched edge request of the source shown on `accept_id_o`. An edge of that same source that is detected in the ack cycle stays pending.
- R10: `prio_sel_i` 0..N_IRQ-1 selects the IRQ priority registers and N_IRQ..N_IRQ+N_PER-1 selects the peripheral ones. A write takes effect from the next cycle. All levels reset to 0. With `irq_edge_i[n]`=1, IRQ line n is rising-edge latched; with 0 it follows the synchronized input. After reset `accept_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request pin |
| nmi_rise_i | input | 1 | 1: rising edge triggers, 0: falling edge |
| dbg_brk_i | input | 1 | Debug-break request, level |
| sdbg_i | input | 1 | Serial-debug request, rising edge |
| irq_i | input | N_IRQ | External IRQ lines |
| irq_edge_i | input | N_IRQ | Per-line mode, 1 edge, 0 level |
| per_i | input | N_PER | Peripheral request lines, level |
| prio_we_i | input | 1 | Priority register write strobe |
| prio_sel_i | input | SEL_W | Priority register select |
| prio_lvl_i | input | 4 | Priority level to write |
| mask_i | input | 4 | Current status-register mask level |
| ack_i | input | 1 | CPU acknowledge of the shown source |
| accept_o | output | 1 | An interrupt is being offered |
| accept_id_o | output | ID_W | Source number of the winner |
| new_mask_o | output | 4 | Mask value for exception entry |

## Verification
Two functions can land in the same cycle: the clear from an acknowledge and a fresh edge on that source. The bench schedules a second edge on an edge-mode IRQ line so that its detection cycle coincides with the cycle in which `ack_i` acknowledges the earlier latched request. It then checks that the source is still offered with its level as the new mask, and that a later plain acknowledge clears it. A second overlap, level ties across source classes and against the debug requests, is judged by the reported source number.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LVL_W    = 5;
  localparam int unsigned MASK_W   = 4;
  localparam int unsigned LVL_NMI  = 16;
  localparam int unsigned LVL_DBG  = 15;
  localparam int unsigned SRC_NMI  = 0;
  localparam int unsigned SRC_BRK  = 1;
  localparam int unsigned SRC_SDBG = 2;
  localparam int unsigned SRC_IRQ0 = 3;
  localparam int unsigned N_FIXED  = 3;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [MASK_W-1:0] mask_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic rise_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, hit;

  // compare against last cycle's value only; select change alone is no edge
  assign hit = en_i & (rise_i ? (sig_i & ~prev_q) : (~sig_i & prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      pend_q <= hit | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 11,
  parameter int unsigned ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            req_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  input  mask_t                       mask_i,
  output logic                        accept_o,
  output logic [ID_W-1:0]             id_o,
  output mask_t                       new_mask_o
);
  lvl_t            best_lvl;
  logic [ID_W-1:0] best_id;

  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    // ascending scan with strict compare: ties stay with lower number
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (req_i[i] && (lvl_i[i] > {1'b0, mask_i}) && (lvl_i[i] > best_lvl)) begin
        best_lvl = lvl_i[i];
        best_id  = ID_W'(i);
      end
    end
  end

  assign accept_o   = (best_lvl != '0);
  assign id_o       = best_id;
  assign new_mask_o = (best_lvl == lvl_t'(LVL_NMI)) ? mask_t'(LVL_DBG) : best_lvl[MASK_W-1:0];
endmodule

// File: rtl/intc_accept.sv
module intc_accept
  import intc_pkg::*;
#(
  parameter int unsigned N_IRQ = 4,
  parameter int unsigned N_PER = 4,
  localparam int unsigned N_PR  = N_IRQ + N_PER,
  localparam int unsigned N_SRC = N_FIXED + N_PR,
  localparam int unsigned SEL_W = (N_PR > 1) ? $clog2(N_PR) : 1,
  localparam int unsigned ID_W  = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              nmi_rise_i,
  input  logic              dbg_brk_i,
  input  logic              sdbg_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_IRQ-1:0]  irq_edge_i,
  input  logic [N_PER-1:0]  per_i,
  input  logic              prio_we_i,
  input  logic [SEL_W-1:0]  prio_sel_i,
  input  logic [3:0]        prio_lvl_i,
  input  logic [3:0]        mask_i,
  input  logic              ack_i,
  output logic              accept_o,
  output logic [ID_W-1:0]   accept_id_o,
  output logic [3:0]        new_mask_o
);
  localparam int unsigned RAW_W = N_FIXED + N_PR;

  logic [RAW_W-1:0]            raw_s;
  logic                        nmi_s, brk_s, sdbg_s;
  logic [N_IRQ-1:0]            irq_s, irq_lat, irq_req;
  logic [N_PER-1:0]            per_s;
  logic                        nmi_pend, sdbg_pend;
  logic [N_SRC-1:0]            clr;
  logic [N_SRC-1:0]            req;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [N_PR-1:0][MASK_W-1:0] prio_q;

  intc_sync #(.W(RAW_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({per_i, irq_i, sdbg_i, dbg_brk_i, nmi_i}),
    .q_o   (raw_s)
  );

  assign nmi_s  = raw_s[0];
  assign brk_s  = raw_s[1];
  assign sdbg_s = raw_s[2];
  assign irq_s  = raw_s[N_FIXED +: N_IRQ];
  assign per_s  = raw_s[N_FIXED+N_IRQ +: N_PER];

  // ack clears only the source currently offered
  always_comb begin
    for (int i = 0; i < int'(N_SRC); i++) begin
      clr[i] = ack_i & accept_o & (accept_id_o == ID_W'(i));
    end
  end

  intc_edge_latch u_nmi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (nmi_s),
    .rise_i(nmi_rise_i),
    .en_i  (1'b1),
    .clr_i (clr[SRC_NMI]),
    .pend_o(nmi_pend)
  );

  intc_edge_latch u_sdbg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sdbg_s),
    .rise_i(1'b1),
    .en_i  (1'b1),
    .clr_i (clr[SRC_SDBG]),
    .pend_o(sdbg_pend)
  );

  for (genvar g = 0; g < int'(N_IRQ); g++) begin : g_irq
    intc_edge_latch u_lat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (irq_s[g]),
      .rise_i(1'b1),
      .en_i  (irq_edge_i[g]),
      .clr_i (clr[SRC_IRQ0+g]),
      .pend_o(irq_lat[g])
    );
    assign irq_req[g] = irq_edge_i[g] ? irq_lat[g] : irq_s[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
    end else if (prio_we_i && (32'(prio_sel_i) < N_PR)) begin
      prio_q[prio_sel_i] <= prio_lvl_i;
    end
  end

  assign req[SRC_NMI]  = nmi_pend;
  assign req[SRC_BRK]  = brk_s;
  assign req[SRC_SDBG] = sdbg_pend;
  assign req[N_FIXED +: N_IRQ]       = irq_req;
  assign req[N_FIXED+N_IRQ +: N_PER] = per_s;

  assign lvl[SRC_NMI]  = lvl_t'(LVL_NMI);
  assign lvl[SRC_BRK]  = lvl_t'(LVL_DBG);
  assign lvl[SRC_SDBG] = lvl_t'(LVL_DBG);
  for (genvar p = 0; p < int'(N_PR); p++) begin : g_lvl
    assign lvl[N_FIXED+p] = {1'b0, prio_q[p]};
  end

  intc_arb #(.N_SRC(N_SRC), .ID_W(ID_W)) u_arb (
    .req_i     (req),
    .lvl_i     (lvl),
    .mask_i    (mask_i),
    .accept_o  (accept_o),
    .id_o      (accept_id_o),
    .new_mask_o(new_mask_o)
  );
endmodule

// File: rtl/intc_accept_chk.sv
module intc_accept_chk #(
  parameter int unsigned ID_W  = 4,
  parameter int unsigned N_SRC = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      mask_i,
  input logic            ack_i,
  input logic            accept_o,
  input logic [ID_W-1:0] accept_id_o,
  input logic [3:0]      new_mask_o,
  input logic            nmi_s,
  input logic            nmi_pend
);
  p_lvl0_never_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> new_mask_o != 4'd0);

  p_nmi_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend |-> (accept_o && accept_id_o == '0 && new_mask_o == 4'd15));

  p_fixed15_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && (accept_id_o == ID_W'(1) || accept_id_o == ID_W'(2))) |-> new_mask_o == 4'd15);

  p_above_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && accept_id_o >= ID_W'(3)) |-> new_mask_o > mask_i);

  p_id_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> 32'(accept_id_o) < N_SRC);

  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && accept_o && accept_id_o == '0 && $stable(nmi_s)) |=> !nmi_pend);
endmodule

bind intc_accept intc_accept_chk #(.ID_W(ID_W), .N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mask_i     (mask_i),
  .ack_i      (ack_i),
  .accept_o   (accept_o),
  .accept_id_o(accept_id_o),
  .new_mask_o (new_mask_o),
  .nmi_s      (nmi_s),
  .nmi_pend   (nmi_pend)
);

// File: tb/tb_intc_accept.sv
`timescale 1ns/1ps
module tb_intc_accept;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nmi_i = 1'b0, nmi_rise_i = 1'b1, dbg_brk_i = 1'b0, sdbg_i = 1'b0;
  logic [3:0] irq_i = '0, irq_edge_i = 4'b1000, per_i = '0;
  logic       prio_we_i = 1'b0;
  logic [2:0] prio_sel_i = '0;
  logic [3:0] prio_lvl_i = '0, mask_i = '0;
  logic       ack_i = 1'b0;
  logic       accept_o;
  logic [3:0] accept_id_o, new_mask_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  intc_accept #(.N_IRQ(4), .N_PER(4)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .nmi_rise_i(nmi_rise_i),
    .dbg_brk_i(dbg_brk_i), .sdbg_i(sdbg_i), .irq_i(irq_i), .irq_edge_i(irq_edge_i),
    .per_i(per_i), .prio_we_i(prio_we_i), .prio_sel_i(prio_sel_i),
    .prio_lvl_i(prio_lvl_i), .mask_i(mask_i), .ack_i(ack_i),
    .accept_o(accept_o), .accept_id_o(accept_id_o), .new_mask_o(new_mask_o)
  );

  // {per[16:13], mask[12:9], acc[8], id[7:4], new_mask[3:0]}
  // periph levels 5,9,9,0 -> source numbers 7,8,9,10
  localparam logic [16:0] VEC [8] = '{
    {4'b0001, 4'd0,  1'b1, 4'd7, 4'd5},  // R8
    {4'b0001, 4'd5,  1'b0, 4'd0, 4'd0},  // R6 equal to mask
    {4'b0001, 4'd4,  1'b1, 4'd7, 4'd5},  // R6 one above
    {4'b0110, 4'd0,  1'b1, 4'd8, 4'd9},  // R7 tie
    {4'b0110, 4'd9,  1'b0, 4'd0, 4'd0},  // R6
    {4'b1000, 4'd0,  1'b0, 4'd0, 4'd0},  // R1 level 0
    {4'b1111, 4'd8,  1'b1, 4'd8, 4'd9},  // R7
    {4'b0111, 4'd15, 1'b0, 4'd0, 4'd0}   // R6
  };

  task automatic chk(input string tag, input logic ea, input logic [3:0] eid, input logic [3:0] enm);
    checks++;
    if (accept_o !== ea || (ea && (accept_id_o !== eid || new_mask_o !== enm))) begin
      errors++;
      $display("FAIL %s actual acc=%0b id=%0d mask=%0d expected acc=%0b id=%0d mask=%0d",
               tag, accept_o, accept_id_o, new_mask_o, ea, eid, enm);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [3:0] l);
    prio_we_i = 1'b1; prio_sel_i = sel; prio_lvl_i = l;
    cyc(1);
    prio_we_i = 1'b0;
  endtask

  task automatic ack1();
    ack_i = 1'b1;
    cyc(1);
    ack_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R10 reset", 1'b0, 4'd0, 4'd0);
    rst_ni = 1'b1;
    cyc(2);
    chk("R10 after reset", 1'b0, 4'd0, 4'd0);
    wr(3'd0, 4'd3); wr(3'd1, 4'd7); wr(3'd2, 4'd9); wr(3'd3, 4'd12);
    wr(3'd4, 4'd5); wr(3'd5, 4'd9); wr(3'd6, 4'd9); wr(3'd7, 4'd0);

    for (int v = 0; v < 8; v++) begin
      per_i = VEC[v][16:13];
      mask_i = VEC[v][12:9];
      cyc(3);
      chk($sformatf("R1 R6 R7 R8 vec%0d", v), VEC[v][8], VEC[v][7:4], VEC[v][3:0]);
    end
    per_i = '0; mask_i = '0;

    wr(3'd7, 4'd4);
    per_i = 4'b1000;
    cyc(3);
    chk("R10 prio rewrite", 1'b1, 4'd10, 4'd4);
    per_i = 4'b0010; irq_i = 4'b0100;
    cyc(3);
    chk("R7 irq beats periph on tie", 1'b1, 4'd5, 4'd9);
    per_i = '0; irq_i = '0;
    cyc(3);
    chk("R10 level irq follows input", 1'b0, 4'd0, 4'd0);

    mask_i = 4'd14; dbg_brk_i = 1'b1;
    cyc(3);
    chk("R4 debug break", 1'b1, 4'd1, 4'd15);
    mask_i = 4'd15;
    cyc(1);
    chk("R4 mask 15 blocks", 1'b0, 4'd0, 4'd0);
    mask_i = 4'd14; sdbg_i = 1'b1;
    cyc(2);
    sdbg_i = 1'b0;
    cyc(3);
    chk("R7 break before serial debug", 1'b1, 4'd1, 4'd15);
    dbg_brk_i = 1'b0;
    cyc(3);
    chk("R5 serial debug latched", 1'b1, 4'd2, 4'd15);
    ack1();
    chk("R9 ack clears serial debug", 1'b0, 4'd0, 4'd0);

    mask_i = 4'd15; nmi_rise_i = 1'b1; nmi_i = 1'b1;
    cyc(4);
    chk("R2 nmi over mask 15", 1'b1, 4'd0, 4'd15);
    ack1();
    cyc(2);
    chk("R9 nmi cleared by ack", 1'b0, 4'd0, 4'd0);
    nmi_rise_i = 1'b0;
    cyc(4);
    chk("R3 select change no request", 1'b0, 4'd0, 4'd0);
    nmi_i = 1'b0;
    cyc(4);
    chk("R3 falling edge", 1'b1, 4'd0, 4'd15);
    ack1();
    nmi_rise_i = 1'b1;
    cyc(4);
    chk("R3 select back no request", 1'b0, 4'd0, 4'd0);

    mask_i = 4'd0; irq_i = 4'b1000;
    cyc(3);
    irq_i = 4'b0000;
    cyc(3);
    chk("R10 edge irq latched", 1'b1, 4'd6, 4'd12);
    ack1();
    chk("R9 plain ack clears irq", 1'b0, 4'd0, 4'd0);
    irq_i = 4'b1000;
    cyc(3);
    irq_i = 4'b0000;
    cyc(3);
    chk("R9 irq pending again", 1'b1, 4'd6, 4'd12);
    irq_i = 4'b1000;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    ack_i = 1'b1;
    cyc(1);
    ack_i = 1'b0;
    chk("R9 edge in ack cycle kept", 1'b1, 4'd6, 4'd12);
    ack1();
    chk("R9 second ack clears", 1'b0, 4'd0, 4'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule